// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block prepares the second operand of an arithmetic or logical unit. It takes a data word and moves it by a variable distance in one of five ways: left with zero fill, right with zero fill, right with sign fill, rotation, and a one-place rotation that passes through the carry flag. Along with the moved word it delivers a carry bit, so that logical operations can set the carry flag from the shifter rather than from an adder.

The distance comes from one of two sources. The first is a 5-bit field carried in the instruction. The second is the low byte of a register, which can hold values of 32 or more. Such large distances give defined results rather than wrapping silently. Internally the block is a combinational path that registers its result, so the moved word and carry appear one clock after the inputs are presented.

Top module: `opnd_shifter`

## Requirements
- R1: While `rst` is high at a rising edge, `resVal` is loaded with zero and `carryOut` with 0.
- R2: The result and carry for the inputs present at a rising edge appear at the outputs after that edge and are held until the next edge.
- R3: Kind code 0 (left, zero fill) by n in 1..31 gives `opVal << n`, and the carry is bit 32-n of `opVal`.
- R4: Kind code 1 (right, zero fill) by n in 1..31 gives `opVal >> n`, and the carry is bit n-1 of `opVal`.
- R5: Kind code 2 (right, sign fill) by n in 1..31 copies bit 31 into the n vacated top bits, and the carry is bit n-1 of `opVal`.
- R6: Kind code 3 (rotate) by n in 1..31 gives `(opVal >> n) | (opVal << (32-n))`, and the carry is bit n-1 of `opVal`.
- R7: Kind code 4 (rotate through carry) ignores the distance. It gives `{carryIn, opVal[31:1]}`, and the carry is `opVal[0]`.
- R8: When `amtFromReg` is 1 the distance is the whole of `amtReg`, and `amtImm` has no effect. When it is 0 the distance is `amtImm`, and `amtReg` has no effect.
- R9: For kind codes 0 to 3, a distance of zero passes `opVal` through unchanged, and `carryOut` equals `carryIn`.
- R10: For kind codes 0 and 1 with a distance of 32 or more, the result is zero. At exactly 32 the carry is bit 0 for kind 0 or bit 31 for kind 1. Above 32 the carry is 0.
- R11: For kind code 2 with a distance of 32 or more, every result bit equals bit 31 of `opVal`, and so does the carry.
- R12: For kind code 3 with a register distance of 32 or more, the rotation uses the distance modulo 32. A nonzero multiple of 32 leaves `opVal` unchanged, with the carry equal to bit 31.
- R13: Kind codes 5 to 7 pass `opVal` through unchanged, and `carryOut` equals `carryIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opVal | input | 32 | Data word to be moved |
| shiftKind | input | 3 | Kind of move: 0 left, 1 right logical, 2 right arithmetic, 3 rotate, 4 rotate through carry |
| amtFromReg | input | 1 | 1 selects the register distance, 0 selects the immediate distance |
| amtImm | input | 5 | Immediate distance, 0 to 31 |
| amtReg | input | 8 | Low byte of a register used as the distance |
| carryIn | input | 1 | Current carry flag |
| resVal | output | 32 | Moved word, registered |
| carryOut | output | 1 | Last bit moved out, or the passed-through carry, registered |

## Verification
Each output is a registered function of a single set of inputs, so a wrong decode or a wrong stage setting shows up in `resVal` or `carryOut` on the very next edge, with no history to hide it. A stage enable stuck at one value shifts by a distance that is off by a power of two. A wrong fill choice corrupts only the top bits. A wrong carry index shows up only in `carryOut`, so the result and the carry are compared as separate fields. The distances 0, 31, 32, 33 and above 32 each take their own decode branch, so each is driven directly for every kind that treats it specially.

// File: rtl/opnd_shift_pkg.sv
package opnd_shift_pkg;

  typedef enum logic [2:0] {
    KIND_LSL = 3'd0,
    KIND_LSR = 3'd1,
    KIND_ASR = 3'd2,
    KIND_ROR = 3'd3,
    KIND_RRX = 3'd4
  } shiftKind_e;

  // Strobes from the decode stage to the datapath
  typedef struct packed {
    logic passThru;   // value and carry flow through untouched
    logic rrxMode;    // one-place rotation through carry
    logic leftDir;    // left move, done by bit reversal
    logic fillSign;   // vacated bits take the sign
    logic wrap;       // vacated bits take the bits moved out
    logic clearAll;   // logical move of a full word or more
    logic edgeCarry;  // clearAll at exactly the word width
    logic signAll;    // arithmetic move of a full word or more
    logic wholeTurn;  // rotation by a nonzero multiple of the width
  } shiftStrobes_t;

endpackage

// File: rtl/opnd_shift_ctrl.sv
module opnd_shift_ctrl
  import opnd_shift_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int REG_AMT_W = 8,
  localparam int AMT_W    = $clog2(WIDTH)
) (
  input  logic [2:0]           shiftKind,
  input  logic                 amtFromReg,
  input  logic [AMT_W-1:0]     amtImm,
  input  logic [REG_AMT_W-1:0] amtReg,
  output shiftStrobes_t        strb,
  output logic [AMT_W-1:0]     amt
);

  logic [REG_AMT_W-1:0] rawAmt;
  logic                 zeroAmt;
  logic                 aboveRange;
  logic                 exactWidth;
  shiftKind_e           kind;

  assign rawAmt     = amtFromReg ? amtReg : REG_AMT_W'(amtImm);
  assign amt        = rawAmt[AMT_W-1:0];
  assign zeroAmt    = (rawAmt == '0);
  assign aboveRange = |rawAmt[REG_AMT_W-1:AMT_W];
  assign exactWidth = (rawAmt == REG_AMT_W'(WIDTH));
  assign kind       = shiftKind_e'(shiftKind);

  always_comb begin
    strb = '0;
    case (kind)
      KIND_LSL: begin
        strb.leftDir = 1'b1;
        if (zeroAmt) begin
          strb.passThru = 1'b1;
        end else if (aboveRange) begin
          strb.clearAll  = 1'b1;
          strb.edgeCarry = exactWidth;
        end
      end
      KIND_LSR: begin
        if (zeroAmt) begin
          strb.passThru = 1'b1;
        end else if (aboveRange) begin
          strb.clearAll  = 1'b1;
          strb.edgeCarry = exactWidth;
        end
      end
      KIND_ASR: begin
        strb.fillSign = 1'b1;
        if (zeroAmt) begin
          strb.passThru = 1'b1;
        end else if (aboveRange) begin
          strb.signAll = 1'b1;
        end
      end
      KIND_ROR: begin
        strb.wrap = 1'b1;
        if (zeroAmt) begin
          strb.passThru = 1'b1;
        end else if (amt == '0) begin
          strb.wholeTurn = 1'b1;
        end
      end
      KIND_RRX: begin
        strb.rrxMode = 1'b1;
      end
      default: begin
        strb.passThru = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/opnd_shift_dp.sv
module opnd_shift_dp
  import opnd_shift_pkg::*;
#(
  parameter int WIDTH  = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opVal,
  input  logic             carryIn,
  input  shiftStrobes_t    strb,
  input  logic [AMT_W-1:0] amt,
  output logic [WIDTH-1:0] resVal,
  output logic             carryOut
);

  logic [WIDTH-1:0] revIn;
  logic [WIDTH-1:0] preVal;
  logic [WIDTH-1:0] revOut;
  logic [WIDTH-1:0] moved;
  logic [WIDTH-1:0] stg [0:AMT_W];
  logic             fillBit;
  logic             lastOut;
  logic             edgeBit;
  logic [WIDTH-1:0] nextRes;
  logic             nextCarry;

  // Left moves reuse the right-moving stages on the reversed word
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign revIn[i]  = opVal[WIDTH-1-i];
    assign revOut[i] = stg[AMT_W][WIDTH-1-i];
  end

  assign preVal  = strb.leftDir ? revIn : opVal;
  assign fillBit = strb.fillSign & opVal[WIDTH-1];
  assign stg[0]  = preVal;

  // Logarithmic stages: stage k moves by 2**k when amt[k] is set
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [STEP-1:0] fillK;
    assign fillK      = strb.wrap ? stg[k][STEP-1:0] : {STEP{fillBit}};
    assign stg[k+1]   = amt[k] ? {fillK, stg[k][WIDTH-1:STEP]} : stg[k];
  end

  assign moved   = strb.leftDir ? revOut : stg[AMT_W];
  assign lastOut = preVal[amt - AMT_W'(1)];
  assign edgeBit = strb.leftDir ? opVal[0] : opVal[WIDTH-1];

  always_comb begin
    nextRes   = moved;
    nextCarry = lastOut;
    if (strb.passThru) begin
      nextRes   = opVal;
      nextCarry = carryIn;
    end else if (strb.rrxMode) begin
      nextRes   = {carryIn, opVal[WIDTH-1:1]};
      nextCarry = opVal[0];
    end else if (strb.clearAll) begin
      nextRes   = '0;
      nextCarry = strb.edgeCarry & edgeBit;
    end else if (strb.signAll) begin
      nextRes   = {WIDTH{opVal[WIDTH-1]}};
      nextCarry = opVal[WIDTH-1];
    end else if (strb.wholeTurn) begin
      nextRes   = opVal;
      nextCarry = opVal[WIDTH-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resVal   <= '0;
      carryOut <= 1'b0;
    end else begin
      resVal   <= nextRes;
      carryOut <= nextCarry;
    end
  end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opnd_shift_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int REG_AMT_W = 8,
  localparam int AMT_W    = $clog2(WIDTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WIDTH-1:0]     opVal,
  input  logic [2:0]           shiftKind,
  input  logic                 amtFromReg,
  input  logic [AMT_W-1:0]     amtImm,
  input  logic [REG_AMT_W-1:0] amtReg,
  input  logic                 carryIn,
  output logic [WIDTH-1:0]     resVal,
  output logic                 carryOut
);

  shiftStrobes_t    strb;
  logic [AMT_W-1:0] amt;

  opnd_shift_ctrl #(.WIDTH(WIDTH), .REG_AMT_W(REG_AMT_W)) u_ctrl (
    .shiftKind (shiftKind),
    .amtFromReg(amtFromReg),
    .amtImm    (amtImm),
    .amtReg    (amtReg),
    .strb      (strb),
    .amt       (amt)
  );

  opnd_shift_dp #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .opVal   (opVal),
    .carryIn (carryIn),
    .strb    (strb),
    .amt     (amt),
    .resVal  (resVal),
    .carryOut(carryOut)
  );

endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk #(
  parameter int WIDTH     = 32,
  parameter int REG_AMT_W = 8,
  localparam int AMT_W    = $clog2(WIDTH)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [WIDTH-1:0]     opVal,
  input logic [2:0]           shiftKind,
  input logic                 amtFromReg,
  input logic [AMT_W-1:0]     amtImm,
  input logic [REG_AMT_W-1:0] amtReg,
  input logic                 carryIn,
  input logic [WIDTH-1:0]     resVal,
  input logic                 carryOut
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (resVal == '0 && !carryOut));

  // R7
  rrx_rotate_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(shiftKind) == 3'd4) |->
      (resVal == {$past(carryIn), $past(opVal[WIDTH-1:1])} && carryOut == $past(opVal[0])));

  // R9
  zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(shiftKind) < 3'd4 &&
     ($past(amtFromReg) ? ($past(amtReg) == '0) : ($past(amtImm) == '0))) |->
      (resVal == $past(opVal) && carryOut == $past(carryIn)));

  // R10
  logic_over_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(amtFromReg) && $past(amtReg) > REG_AMT_W'(WIDTH) &&
     $past(shiftKind) < 3'd2) |-> (resVal == '0 && !carryOut));

  // R11
  asr_over_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(amtFromReg) && $past(amtReg) >= REG_AMT_W'(WIDTH) &&
     $past(shiftKind) == 3'd2) |->
      (resVal == {WIDTH{$past(opVal[WIDTH-1])}} && carryOut == $past(opVal[WIDTH-1])));

  // R13
  unused_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(shiftKind) > 3'd4) |->
      (resVal == $past(opVal) && carryOut == $past(carryIn)));

endmodule

bind opnd_shifter opnd_shifter_chk #(.WIDTH(WIDTH), .REG_AMT_W(REG_AMT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .opVal     (opVal),
  .shiftKind (shiftKind),
  .amtFromReg(amtFromReg),
  .amtImm    (amtImm),
  .amtReg    (amtReg),
  .carryIn   (carryIn),
  .resVal    (resVal),
  .carryOut  (carryOut)
);

// File: tb/tb_opnd_shifter.sv
module tb_opnd_shifter;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opVal = '0;
  logic [2:0]  shiftKind = '0;
  logic        amtFromReg = 1'b0;
  logic [4:0]  amtImm = '0;
  logic [7:0]  amtReg = '0;
  logic        carryIn = 1'b0;
  logic [31:0] resVal;
  logic        carryOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_shifter dut (
    .clk(clk), .rst(rst), .opVal(opVal), .shiftKind(shiftKind),
    .amtFromReg(amtFromReg), .amtImm(amtImm), .amtReg(amtReg),
    .carryIn(carryIn), .resVal(resVal), .carryOut(carryOut)
  );

  // {req[3:0], kind[2:0], fromReg, imm[4:0], reg[7:0], cin, op[31:0], expRes[31:0], expC}
  localparam logic [86:0] VEC [NVEC] = '{
    {4'd3,  3'd0, 1'b0, 5'd2,  8'd0,   1'b1, 32'h00000005, 32'h00000014, 1'b0}, // R3
    {4'd3,  3'd0, 1'b0, 5'd1,  8'd0,   1'b0, 32'h80000004, 32'h00000008, 1'b1}, // R3
    {4'd4,  3'd1, 1'b0, 5'd4,  8'd0,   1'b0, 32'h000000F8, 32'h0000000F, 1'b1}, // R4
    {4'd5,  3'd2, 1'b0, 5'd4,  8'd0,   1'b1, 32'h80000010, 32'hF8000001, 1'b0}, // R5
    {4'd6,  3'd3, 1'b0, 5'd8,  8'd0,   1'b1, 32'h12345678, 32'h78123456, 1'b0}, // R6
    {4'd7,  3'd4, 1'b0, 5'd0,  8'd0,   1'b1, 32'h00000003, 32'h80000001, 1'b1}, // R7
    {4'd7,  3'd4, 1'b0, 5'd0,  8'd0,   1'b0, 32'h80000002, 32'h40000001, 1'b0}, // R7
    {4'd7,  3'd4, 1'b0, 5'd7,  8'd0,   1'b0, 32'h00000001, 32'h00000000, 1'b1}, // R7
    {4'd9,  3'd0, 1'b0, 5'd0,  8'd0,   1'b1, 32'hDEADBEEF, 32'hDEADBEEF, 1'b1}, // R9
    {4'd9,  3'd1, 1'b1, 5'd9,  8'd0,   1'b0, 32'h12345678, 32'h12345678, 1'b0}, // R9
    {4'd10, 3'd0, 1'b1, 5'd0,  8'd32,  1'b0, 32'h00000001, 32'h00000000, 1'b1}, // R10
    {4'd10, 3'd0, 1'b1, 5'd0,  8'd33,  1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b0}, // R10
    {4'd10, 3'd1, 1'b1, 5'd0,  8'd32,  1'b0, 32'h80000000, 32'h00000000, 1'b1}, // R10
    {4'd10, 3'd1, 1'b1, 5'd0,  8'd200, 1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b0}, // R10
    {4'd11, 3'd2, 1'b1, 5'd0,  8'd40,  1'b0, 32'h80000000, 32'hFFFFFFFF, 1'b1}, // R11
    {4'd11, 3'd2, 1'b1, 5'd0,  8'd32,  1'b1, 32'h7FFFFFFF, 32'h00000000, 1'b0}, // R11
    {4'd12, 3'd3, 1'b1, 5'd0,  8'd36,  1'b0, 32'h0000000F, 32'hF0000000, 1'b1}, // R12
    {4'd12, 3'd3, 1'b1, 5'd0,  8'd32,  1'b0, 32'h80000001, 32'h80000001, 1'b1}, // R12
    {4'd3,  3'd0, 1'b1, 5'd0,  8'd31,  1'b0, 32'h00000003, 32'h80000000, 1'b1}, // R3
    {4'd8,  3'd1, 1'b1, 5'd17, 8'd4,   1'b1, 32'h00000100, 32'h00000010, 1'b0}, // R8
    {4'd8,  3'd1, 1'b0, 5'd4,  8'd200, 1'b1, 32'h00000100, 32'h00000010, 1'b0}, // R8
    {4'd13, 3'd5, 1'b0, 5'd3,  8'd0,   1'b1, 32'hA5A5A5A5, 32'hA5A5A5A5, 1'b1}  // R13
  };

  task automatic check(input string req, input logic [31:0] expRes, input logic expC);
    checks++;
    if (resVal !== expRes || carryOut !== expC) begin
      fails++;
      $display("FAIL %s: got res=%h carry=%b, expected res=%h carry=%b",
               req, resVal, carryOut, expRes, expC);
    end
  endtask

  task automatic drive(input logic [86:0] v);
    shiftKind  = v[82:80];
    amtFromReg = v[79];
    amtImm     = v[78:74];
    amtReg     = v[73:66];
    carryIn    = v[65];
    opVal      = v[64:33];
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2: watchdog expired, got no completion, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    // R1: outputs clear while reset is held with busy inputs
    opVal = 32'hFFFFFFFF; shiftKind = 3'd3; amtImm = 5'd5; carryIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 32'h0, 1'b0);
    rst = 1'b0;

    // Table of vectors, each checked one edge after it is driven
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d", VEC[i][86:83]), VEC[i][32:1], VEC[i][0]);
    end

    // R2: a new input does not reach the outputs before the next edge
    drive(VEC[4]);
    @(negedge clk);
    check("R2", 32'h78123456, 1'b0);
    drive(VEC[3]);
    #1;
    check("R2", 32'h78123456, 1'b0);
    @(negedge clk);
    check("R2", 32'hF8000001, 1'b0);

    // R6: rotate by 31 (register distance 63 wraps to 31)
    opVal = 32'h00000001; shiftKind = 3'd3; amtFromReg = 1'b1; amtReg = 8'd63; carryIn = 1'b0;
    @(negedge clk);
    check("R12", 32'h00000002, 1'b0);

    // R5: sign fill by 31
    opVal = 32'hC0000000; shiftKind = 3'd2; amtFromReg = 1'b0; amtImm = 5'd31;
    @(negedge clk);
    check("R5", 32'hFFFFFFFF, 1'b1);

    // R1: reset mid-run clears the outputs again
    rst = 1'b1;
    @(negedge clk);
    check("R1", 32'h0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R5", 32'hFFFFFFFF, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule